// File: doc/BRIEF.md
# Priority Interrupt Entry and Return Sequencer

This block is the control unit that lets a 16-bit processor core accept a prioritised device interrupt and later return from it. It owns the processor status word, which holds the privilege flag, the running priority level and the three condition-code flags. It also keeps the parked user and supervisor stack pointers. At each instruction boundary it compares the pending device request against the running priority. When the request wins, the block switches stacks, saves the return state on the supervisor stack, raises the privilege and priority, and loads the new program counter from a 256-entry vector table.

A return command undoes these steps. The block restores the saved status word and program counter from the stack, and puts back the user stack pointer if the restored status word says the core is going back to user mode. The sequencer drives one memory access per cycle on a single port. It also issues write strobes for the program counter and for register R6, which the surrounding datapath applies.

The datapath presents the live program counter and R6 on `pc_in` and `r6_in`. It writes new condition codes through `cc_we`/`cc_in`. Memory read data must be valid in the same cycle as the request.

Top module: `irq_seq_top`

## Requirements
- R1: After reset the status word `psr_q` equals 0x8002: bit 15 is 1 (user mode), bits 10:8 are 0 (priority 0), bits 2:0 are 010 (Z set). `busy` is low, and the saved supervisor stack pointer is 0x3000.
- R2: Entry starts only on a clock edge where the block is idle and `req_valid`, `req_enable` and `insn_done` are all high, `req_prio` is strictly greater than `psr_q[10:8]`, and `rti_cmd` is low. An equal or lower priority, a cleared enable or a missing boundary strobe causes no memory access and no status change.
- R3: On entry from user mode (`psr_q[15]`=1), `r6_in` is parked as the user stack pointer and pushes start below the saved supervisor stack pointer. On entry from supervisor mode, pushes continue below `r6_in` and the parked user pointer is kept.
- R4: In the first cycle after acceptance, the block writes the accepted `pc_in` to stack pointer − 1. In the second cycle it writes the unmodified, pre-entry status word to stack pointer − 2 (`mem_we`=1 both times).
- R5: From the cycle after acceptance, `psr_q` has bit 15 = 0, bits 10:8 = `req_prio`, and all other bits 0, so the condition codes are cleared.
- R6: In the third cycle the block reads address 0x0100 + `req_vec`. In that same cycle it asserts `pc_we` with the read word, and asserts `r6_we` with the final stack pointer (stack pointer − 2).
- R7: `busy` is high for exactly the three entry cycles or the two return cycles. While busy, new requests, `rti_cmd` and `cc_we` are ignored.
- R8: On an idle edge with `rti_cmd` high, the next cycle reads `r6_in`. The word read is loaded into `psr_q`, keeping bits 15, 10:8 and 2:0. The cycle after that reads `r6_in`+1 and asserts `pc_we` with that word. `rti_cmd` takes precedence over a simultaneous request.
- R9: In the final return cycle, if the restored bit 15 is 1, `r6_we` carries the parked user pointer and the supervisor pointer becomes `r6_in`+2. Otherwise `r6_we` carries `r6_in`+2.
- R10: When idle, `cc_we` loads `cc_in` into `psr_q[2:0]` on the next edge and leaves the other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Device requests service |
| req_enable | input | 1 | Device interrupt enable |
| req_prio | input | 3 | Priority of the requesting device |
| req_vec | input | 8 | Vector number of the requesting device |
| insn_done | input | 1 | Current instruction has completed |
| rti_cmd | input | 1 | Start a return-from-interrupt sequence |
| pc_in | input | 16 | Live program counter |
| r6_in | input | 16 | Live stack pointer register R6 |
| cc_we | input | 1 | Condition-code write enable |
| cc_in | input | 3 | New condition codes (N,Z,P) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the request cycle |
| pc_we | output | 1 | Load program counter |
| pc_wdata | output | 16 | New program counter |
| r6_we | output | 1 | Load R6 |
| r6_wdata | output | 16 | New R6 value |
| psr_q | output | 16 | Processor status word |
| busy | output | 1 | Entry or return sequence in progress |

## Verification
The hardest case to reach from the ports is a nested interrupt. A higher-priority entry must arrive while a lower one is already in supervisor mode. The stacks must then not swap again, and the two returns must unwind in order: first supervisor to supervisor, then supervisor to user with the user pointer restored. The stimulus reaches this by taking a priority-4 interrupt from user mode, then a priority-6 one, then issuing two returns. A third entry afterwards shows that the supervisor pointer written back by the final return is the one used again.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int PSR_W        = 16;
    localparam int PSR_PRIV_BIT = 15;
    localparam int PSR_PRIO_LSB = 8;
    localparam int PSR_CC_W     = 3;

    // Only privilege, priority and condition-code bits exist in the word
    localparam logic [PSR_W-1:0] PSR_KEEP_MASK = 16'h8707;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH_PC,
        S_PUSH_PSR,
        S_VEC_RD,
        S_POP_PSR,
        S_POP_PC
    } seq_state_e;

endpackage

// File: rtl/irq_take_gate.sv
module irq_take_gate #(
    parameter int PRIO_W = 3
) (
    input  logic              idle,
    input  logic              req_valid,
    input  logic              req_enable,
    input  logic              insn_done,
    input  logic              rti_cmd,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic [PRIO_W-1:0] cur_prio,
    output logic              take
);
    logic prio_wins;

    always_comb begin
        prio_wins = (req_prio > cur_prio);
        take      = idle && req_valid && req_enable && insn_done
                    && !rti_cmd && prio_wins;
    end

endmodule

// File: rtl/irq_psr_fmt.sv
module irq_psr_fmt
    import irq_seq_pkg::*;
#(
    parameter int PRIO_W = 3
) (
    input  logic [PRIO_W-1:0] new_prio,
    input  logic [PSR_W-1:0]  popped_word,
    output logic [PSR_W-1:0]  entry_psr,
    output logic [PSR_W-1:0]  popped_psr
);
    always_comb begin
        entry_psr = '0;
        entry_psr[PSR_PRIO_LSB +: PRIO_W] = new_prio;
        popped_psr = popped_word & PSR_KEEP_MASK;
    end

endmodule

// File: rtl/irq_stack_step.sv
module irq_stack_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] sp,
    output logic [AW-1:0] sp_dec,
    output logic [AW-1:0] sp_inc
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    always_comb begin
        sp_dec = sp - ONE;
        sp_inc = sp + ONE;
    end

endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
    import irq_seq_pkg::*;
#(
    parameter int               AW        = 16,
    parameter int               PRIO_W    = 3,
    parameter int               VEC_W     = 8,
    parameter logic [AW-1:0]    VEC_BASE  = 16'h0100,
    parameter logic [AW-1:0]    SSP_RESET = 16'h3000,
    parameter logic [PSR_W-1:0] PSR_RESET = 16'h8002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_enable,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic [VEC_W-1:0]  req_vec,
    input  logic              insn_done,
    input  logic              rti_cmd,
    input  logic [AW-1:0]     pc_in,
    input  logic [AW-1:0]     r6_in,
    input  logic              cc_we,
    input  logic [PSR_CC_W-1:0] cc_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [PSR_W-1:0]  mem_wdata,
    input  logic [PSR_W-1:0]  mem_rdata,
    output logic              pc_we,
    output logic [AW-1:0]     pc_wdata,
    output logic              r6_we,
    output logic [AW-1:0]     r6_wdata,
    output logic [PSR_W-1:0]  psr_q,
    output logic              busy
);
    localparam logic [AW-1:0] ZERO_AW = '0;

    typedef struct packed {
        seq_state_e        st;
        logic [AW-1:0]     sp;
        logic [AW-1:0]     usp;
        logic [AW-1:0]     ssp;
        logic [PSR_W-1:0]  psr;
        logic [AW-1:0]     spc;
        logic [PSR_W-1:0]  spsr;
        logic [VEC_W-1:0]  vec;
    } seq_regs_t;

    seq_regs_t q, d;

    logic             take;
    logic [PSR_W-1:0] entry_psr, popped_psr;
    logic [AW-1:0]    sp_dec, sp_inc, ssp_dec, r6_dec, r6_unused_inc, ssp_unused_inc;
    logic [AW-1:0]    vec_addr;

    irq_take_gate #(.PRIO_W(PRIO_W)) u_gate (
        .idle       (q.st == S_IDLE),
        .req_valid  (req_valid),
        .req_enable (req_enable),
        .insn_done  (insn_done),
        .rti_cmd    (rti_cmd),
        .req_prio   (req_prio),
        .cur_prio   (q.psr[PSR_PRIO_LSB +: PRIO_W]),
        .take       (take)
    );

    irq_psr_fmt #(.PRIO_W(PRIO_W)) u_fmt (
        .new_prio    (req_prio),
        .popped_word (mem_rdata),
        .entry_psr   (entry_psr),
        .popped_psr  (popped_psr)
    );

    irq_stack_step #(.AW(AW)) u_step_sp (
        .sp(q.sp), .sp_dec(sp_dec), .sp_inc(sp_inc)
    );
    irq_stack_step #(.AW(AW)) u_step_ssp (
        .sp(q.ssp), .sp_dec(ssp_dec), .sp_inc(ssp_unused_inc)
    );
    irq_stack_step #(.AW(AW)) u_step_r6 (
        .sp(r6_in), .sp_dec(r6_dec), .sp_inc(r6_unused_inc)
    );

    always_comb begin
        vec_addr = VEC_BASE + {{(AW-VEC_W){1'b0}}, q.vec};
    end

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ZERO_AW;
        mem_wdata = '0;
        pc_we     = 1'b0;
        pc_wdata  = ZERO_AW;
        r6_we     = 1'b0;
        r6_wdata  = ZERO_AW;

        case (q.st)
            S_IDLE: begin
                if (rti_cmd) begin
                    d.sp = r6_in;
                    d.st = S_POP_PSR;
                end else if (take) begin
                    d.spc  = pc_in;
                    d.spsr = q.psr;
                    d.vec  = req_vec;
                    d.psr  = entry_psr;
                    if (q.psr[PSR_PRIV_BIT]) begin
                        d.usp = r6_in;
                        d.sp  = ssp_dec;
                    end else begin
                        d.sp  = r6_dec;
                    end
                    d.st = S_PUSH_PC;
                end else if (cc_we) begin
                    d.psr[PSR_CC_W-1:0] = cc_in;
                end
            end
            S_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.sp;
                mem_wdata = q.spc;
                d.sp      = sp_dec;
                d.st      = S_PUSH_PSR;
            end
            S_PUSH_PSR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.sp;
                mem_wdata = q.spsr;
                d.st      = S_VEC_RD;
            end
            S_VEC_RD: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr;
                pc_we    = 1'b1;
                pc_wdata = mem_rdata;
                r6_we    = 1'b1;
                r6_wdata = q.sp;
                d.st     = S_IDLE;
            end
            S_POP_PSR: begin
                mem_req  = 1'b1;
                mem_addr = q.sp;
                d.psr    = popped_psr;
                d.sp     = sp_inc;
                d.st     = S_POP_PC;
            end
            S_POP_PC: begin
                mem_req  = 1'b1;
                mem_addr = q.sp;
                pc_we    = 1'b1;
                pc_wdata = mem_rdata;
                r6_we    = 1'b1;
                if (q.psr[PSR_PRIV_BIT]) begin
                    r6_wdata = q.usp;
                    d.ssp    = sp_inc;
                end else begin
                    r6_wdata = sp_inc;
                end
                d.sp = sp_inc;
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= S_IDLE;
            q.sp   <= SSP_RESET;
            q.usp  <= ZERO_AW;
            q.ssp  <= SSP_RESET;
            q.psr  <= PSR_RESET;
            q.spc  <= ZERO_AW;
            q.spsr <= '0;
            q.vec  <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        psr_q = q.psr;
        busy  = (q.st != S_IDLE);
    end

    // R7: no memory traffic outside a sequence
    a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R4: second push lands one word below the first
    a_r4_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_PUSH_PSR) |-> (mem_we && mem_addr == $past(mem_addr) - 16'd1));

    // R2: an accepted entry always raised the running priority
    a_r2_prio_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_PUSH_PC) |->
            (q.psr[PSR_PRIO_LSB +: PRIO_W] > q.spsr[PSR_PRIO_LSB +: PRIO_W]));

    // R5: privileged and condition codes clear while fetching the vector
    a_r5_priv_at_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_VEC_RD) |-> (!psr_q[PSR_PRIV_BIT] && psr_q[2:0] == 3'b000));

    // R6: vector fetch stays inside the table
    a_r6_vec_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_VEC_RD) |-> (mem_addr >= VEC_BASE && !mem_we));

    // R8: second pop reads one word above the first
    a_r8_pop_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_POP_PC) |-> (mem_addr == $past(mem_addr) + 16'd1));

    // R7: busy never lasts more than one sequence from a rise
    a_r7_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we) |=> !busy);

endmodule

// File: tb/irq_seq_top_tb.sv
module irq_seq_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_enable = 1'b0, insn_done = 1'b0, rti_cmd = 1'b0;
    logic [2:0]  req_prio = '0;
    logic [7:0]  req_vec = '0;
    logic [15:0] pc_in = '0, r6_in = '0;
    logic        cc_we = 1'b0;
    logic [2:0]  cc_in = '0;
    logic        mem_req, mem_we, pc_we, r6_we, busy;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_wdata, r6_wdata, psr_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_flag = 1'b0;

    logic [15:0] stk [256];

    logic [1:0]  exp_kind [$];
    logic [15:0] exp_addr [$];
    logic [15:0] exp_data [$];
    string       exp_tag  [$];

    always #2 clk = ~clk;

    irq_seq_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_enable(req_enable),
        .req_prio(req_prio), .req_vec(req_vec),
        .insn_done(insn_done), .rti_cmd(rti_cmd),
        .pc_in(pc_in), .r6_in(r6_in),
        .cc_we(cc_we), .cc_in(cc_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pc_we(pc_we), .pc_wdata(pc_wdata),
        .r6_we(r6_we), .r6_wdata(r6_wdata),
        .psr_q(psr_q), .busy(busy)
    );

    // Memory model: vector table word = {A5, vector}; stack page 0x2Fxx
    always_comb begin
        if (mem_addr[15:8] == 8'h01)      mem_rdata = {8'hA5, mem_addr[7:0]};
        else if (mem_addr[15:8] == 8'h2F) mem_rdata = stk[mem_addr[7:0]];
        else                              mem_rdata = 16'h0000;
    end

    always @(posedge clk)
        if (mem_req && mem_we && mem_addr[15:8] == 8'h2F)
            stk[mem_addr[7:0]] <= mem_wdata;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_item(input logic [1:0] k, input logic [15:0] a,
                               input logic [15:0] dv, input string tag);
        exp_kind.push_back(k); exp_addr.push_back(a);
        exp_data.push_back(dv); exp_tag.push_back(tag);
    endtask

    task automatic take_one(input logic [1:0] k, input logic [15:0] a, input logic [15:0] dv);
        string t;
        n_checks++;
        if (exp_kind.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected event kind=%0d actual=%h/%h expected=none (R2)", k, a, dv);
        end else begin
            t = exp_tag.pop_front();
            if (exp_kind.pop_front() !== k || exp_addr.pop_front() !== a
                || exp_data.pop_front() !== dv) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h/%h expected other", t, k, a, dv);
            end
        end
    endtask

    // Monitor: kind 0 = memory write, 1 = PC load, 2 = R6 load
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_we) take_one(2'd0, mem_addr, mem_wdata);
            if (pc_we)             take_one(2'd1, 16'h0000, pc_wdata);
            if (r6_we)             take_one(2'd2, 16'h0000, r6_wdata);
        end
    end

    task automatic pulse_req(input logic [2:0] p, input logic [7:0] v,
                             input logic en, input logic dn);
        @(posedge clk); #1;
        req_valid = 1'b1; req_enable = en; insn_done = dn; req_prio = p; req_vec = v;
        @(posedge clk); #1;
        req_valid = 1'b0; req_enable = 1'b0; insn_done = 1'b0;
    endtask

    task automatic no_take(input string tag);
        repeat (3) begin
            @(negedge clk);
            check(tag, {15'd0, busy}, 16'd0);
        end
    endtask

    task automatic pulse_rti;
        @(posedge clk); #1; rti_cmd = 1'b1;
        @(posedge clk); #1; rti_cmd = 1'b0;
    endtask

    task automatic write_cc(input logic [2:0] c);
        @(posedge clk); #1; cc_we = 1'b1; cc_in = c;
        @(posedge clk); #1; cc_we = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 16'h0000;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset psr", psr_q, 16'h8002);
        check("R1 reset busy", {15'd0, busy}, 16'd0);

        write_cc(3'b001);
        @(negedge clk);
        check("R10 cc write", psr_q, 16'h8001);

        pulse_req(3'd0, 8'h10, 1'b1, 1'b1); no_take("R2 equal prio");
        pulse_req(3'd5, 8'h10, 1'b0, 1'b1); no_take("R2 enable low");
        pulse_req(3'd5, 8'h10, 1'b1, 1'b0); no_take("R2 no boundary");
        check("R2 psr untouched", psr_q, 16'h8001);

        // Entry A from user mode, with ignored stimulus during busy
        pc_in = 16'h3010; r6_in = 16'h4500;
        expect_item(2'd0, 16'h2FFF, 16'h3010, "R4 push pc A");
        expect_item(2'd0, 16'h2FFE, 16'h8001, "R4 push psr A");
        expect_item(2'd1, 16'h0000, 16'hA580, "R6 vector pc A");
        expect_item(2'd2, 16'h0000, 16'h2FFE, "R3 r6 A");
        pulse_req(3'd4, 8'h80, 1'b1, 1'b1);
        req_valid = 1'b1; req_enable = 1'b1; insn_done = 1'b1; req_prio = 3'd7;
        cc_we = 1'b1; cc_in = 3'b111;
        @(negedge clk); check("R7 busy c1", {15'd0, busy}, 16'd1);
        check("R5 entry psr", psr_q, 16'h0400);
        @(posedge clk); #1;
        req_valid = 1'b0; req_enable = 1'b0; insn_done = 1'b0; cc_we = 1'b0;
        @(negedge clk); check("R7 busy c2", {15'd0, busy}, 16'd1);
        @(negedge clk); check("R7 busy c3", {15'd0, busy}, 16'd1);
        @(negedge clk); check("R7 busy end", {15'd0, busy}, 16'd0);
        check("R7 ignored while busy", psr_q, 16'h0400);

        pc_in = 16'hA580; r6_in = 16'h2FFE;
        pulse_req(3'd3, 8'h11, 1'b1, 1'b1); no_take("R2 lower prio");

        // Entry B nested from supervisor mode
        pc_in = 16'h0200;
        expect_item(2'd0, 16'h2FFD, 16'h0200, "R4 push pc B");
        expect_item(2'd0, 16'h2FFC, 16'h0400, "R4 push psr B");
        expect_item(2'd1, 16'h0000, 16'hA581, "R6 vector pc B");
        expect_item(2'd2, 16'h0000, 16'h2FFC, "R3 r6 B supervisor");
        pulse_req(3'd6, 8'h81, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        check("R5 nested psr", psr_q, 16'h0600);

        // Return B to supervisor
        r6_in = 16'h2FFC;
        expect_item(2'd1, 16'h0000, 16'h0200, "R8 pop pc B");
        expect_item(2'd2, 16'h0000, 16'h2FFE, "R9 r6 to supervisor");
        pulse_rti;
        repeat (3) @(negedge clk);
        check("R8 popped psr B", psr_q, 16'h0400);

        // Return A to user, rti wins over a simultaneous request
        r6_in = 16'h2FFE;
        expect_item(2'd1, 16'h0000, 16'h3010, "R8 pop pc A");
        expect_item(2'd2, 16'h0000, 16'h4500, "R9 r6 user restore");
        @(posedge clk); #1;
        rti_cmd = 1'b1; req_valid = 1'b1; req_enable = 1'b1; insn_done = 1'b1; req_prio = 3'd7;
        @(posedge clk); #1;
        rti_cmd = 1'b0; req_valid = 1'b0; req_enable = 1'b0; insn_done = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 popped psr A", psr_q, 16'h8001);

        // Entry C from user: supervisor pointer written back by return
        r6_in = 16'h5000; pc_in = 16'h3100;
        write_cc(3'b100);
        expect_item(2'd0, 16'h2FFF, 16'h3100, "R9 ssp restored push pc C");
        expect_item(2'd0, 16'h2FFE, 16'h8004, "R4 push psr C pre-change");
        expect_item(2'd1, 16'h0000, 16'hA502, "R6 vector pc C");
        expect_item(2'd2, 16'h0000, 16'h2FFE, "R3 r6 C");
        pulse_req(3'd1, 8'h02, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        check("R5 psr C", psr_q, 16'h0100);

        r6_in = 16'h2FFE;
        expect_item(2'd1, 16'h0000, 16'h3100, "R8 pop pc C");
        expect_item(2'd2, 16'h0000, 16'h5000, "R9 r6 user C");
        pulse_rti;
        repeat (3) @(negedge clk);
        check("R8 psr C restored", psr_q, 16'h8004);

        check("R2 no pending expected items", exp_kind.size()[15:0], 16'd0);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished (R7)");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule